// File: doc/BRIEF.md
# Quadrature Chroma Phase Generator

The block turns a clock running at four times the colour subcarrier frequency into the digital switching phases for a pair of balanced chroma modulators. A counter divides the clock by four. The counter value is decoded into a U switching signal at the 0 degree reference and a V switching signal that lags U by a quarter cycle, which is the 90 degree position. Every output also has a registered complement, so that a balanced switch gets both legs without an inverter delay between them.

With the standard-select input set to NTSC, V stays at 90 degrees and the line strobe has no effect. With PAL selected, each line-start strobe toggles a phase flag. The flag moves V between 90 and 270 degrees, so the V phase changes once per line. A new flag value reaches V only at the phase boundary where the 90 degree and 270 degree waveforms cross. At that point the switch leaves the V waveform unchanged, so no pulse shorter than half a subcarrier period appears.

Top module: `chroma_phase_gen`

## Requirements
- R1: While rst_ni is low, u_o=1, u_n_o=0, v_o=0 and v_n_o=1. The divider count and the phase flag are cleared.
- R2: The divider count advances by one on every clock, modulo 4, starting from 0 after reset. u_o is high when the count of the previous cycle was 0 or 1. The outputs are registered and lag the count by one clock.
- R3: With pal_mode_i=0, v_o is high when the count of the previous cycle was 1 or 2, which is 90 degrees. line_start_i has no effect on v_o.
- R4: With pal_mode_i=1, each clock with line_start_i=1 toggles a phase flag. While the applied flag is 1, v_o is the inverse of the 90 degree waveform: it is high for counts 3 and 0, which is 270 degrees. Two strobes leave the flag unchanged.
- R5: The applied flag takes the phase flag's value only on the clock edge that leaves count 2. v_o therefore never stays at one level for less than two clocks.
- R6: A strobe that arrives in the count-2 cycle toggles the phase flag on that same edge. The applied flag loads the old flag value there, so the new value reaches v_o one divider period later.
- R7: With pal_mode_i=0 the phase flag is held at 0. After leaving PAL, V returns to 90 degrees at the next load point.
- R8: u_n_o is always the inverse of u_o, and v_n_o is always the inverse of v_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at four times the subcarrier frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pal_mode_i | input | 1 | Standard select: 1 = PAL alternation, 0 = NTSC |
| line_start_i | input | 1 | One-clock line-start strobe, synchronous to clk_i |
| u_o | output | 1 | U switching phase, 0 degrees |
| u_n_o | output | 1 | Complement of u_o |
| v_o | output | 1 | V switching phase, 90 or 270 degrees |
| v_n_o | output | 1 | Complement of v_o |

## Verification
Two events can fall on the same edge: a line strobe toggling the phase flag, and the load of that flag into the applied phase on the exit from count 2. The bench sweeps the strobe across all four counter phases on successive PAL lines. Each arrangement is judged against a cycle-accurate model of the count and both flags, which must show the deferred flip for the count-2 case. It also measures every V level run, to confirm that none of these collisions produces a shortened pulse.

// File: rtl/chroma_pkg.sv
package chroma_pkg;
  localparam int unsigned PHASES = 4;
  localparam int unsigned CNT_W  = $clog2(PHASES);
  localparam int unsigned QTR    = PHASES / 4;
  localparam int unsigned HALF   = PHASES / 2;
  // last count before the 90/270 crossing point
  localparam logic [CNT_W-1:0] LOAD_CNT = CNT_W'(PHASES - QTR - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PHASES - 1);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic u;
    logic u_n;
    logic v;
    logic v_n;
  } sw_t;
endpackage

// File: rtl/phase_counter.sv
module phase_counter
  import chroma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output cnt_t cnt_o,
  output logic load_o
);
  cnt_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cnt_q == LAST_CNT) cnt_q <= '0;
    else                        cnt_q <= cnt_q + cnt_t'(1);
  end

  assign cnt_o  = cnt_q;
  assign load_o = (cnt_q == LOAD_CNT);
endmodule

// File: rtl/pal_flag.sv
module pal_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pal_mode_i,
  input  logic line_start_i,
  input  logic load_i,
  output logic invert_o
);
  logic line_q;
  logic applied_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          line_q <= 1'b0;
    else if (!pal_mode_i) line_q <= 1'b0;
    else if (line_start_i) line_q <= ~line_q;
  end

  // flag reaches V only at the 90/270 crossing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     applied_q <= 1'b0;
    else if (load_i) applied_q <= line_q;
  end

  assign invert_o = applied_q;

  assert_apply_on_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(applied_q) |-> $past(load_i));
endmodule

// File: rtl/phase_decode.sv
module phase_decode
  import chroma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t cnt_i,
  input  logic invert_i,
  output sw_t  sw_o
);
  cnt_t lag_cnt;
  logic u_d;
  logic v_d;
  sw_t  sw_q;

  assign lag_cnt = cnt_i - cnt_t'(QTR);
  assign u_d     = (cnt_i < cnt_t'(HALF));
  assign v_d     = (lag_cnt < cnt_t'(HALF)) ^ invert_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_q <= '{u: 1'b1, u_n: 1'b0, v: 1'b0, v_n: 1'b1};
    else         sw_q <= '{u: u_d, u_n: ~u_d, v: v_d, v_n: ~v_d};
  end

  assign sw_o = sw_q;

  assert_comp_u_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_q.u_n != sw_q.u);
  assert_comp_v_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_q.v_n != sw_q.v);
  assert_u_half_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sw_q.u) |=> $stable(sw_q.u));
  assert_v_min_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sw_q.v) |=> $stable(sw_q.v));
endmodule

// File: rtl/chroma_phase_gen.sv
module chroma_phase_gen
  import chroma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pal_mode_i,
  input  logic line_start_i,
  output logic u_o,
  output logic u_n_o,
  output logic v_o,
  output logic v_n_o
);
  cnt_t cnt;
  logic load;
  logic invert;
  sw_t  sw;

  phase_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .load_o (load)
  );

  pal_flag u_flag (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pal_mode_i   (pal_mode_i),
    .line_start_i (line_start_i),
    .load_i       (load),
    .invert_o     (invert)
  );

  phase_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt),
    .invert_i (invert),
    .sw_o     (sw)
  );

  assign u_o   = sw.u;
  assign u_n_o = sw.u_n;
  assign v_o   = sw.v;
  assign v_n_o = sw.v_n;
endmodule

// File: tb/sim_chroma_phase_gen.sv
`timescale 1ns/100ps
module sim_chroma_phase_gen;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pal_mode_i = 1'b0;
  logic line_start_i = 1'b0;
  logic u_o, u_n_o, v_o, v_n_o;

  always #2.5 clk = ~clk;

  chroma_phase_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pal_mode_i(pal_mode_i),
    .line_start_i(line_start_i), .u_o(u_o), .u_n_o(u_n_o),
    .v_o(v_o), .v_n_o(v_n_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_cnt = 0, m_flag = 0, m_app = 0;
  logic exp_u = 1'b1, exp_v = 1'b0;
  logic last_v = 1'b0;
  int run_len = 0;
  bit seen_edge = 0;

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: check at negedge, drive, model the edge
  task automatic cyc(bit pal, bit strobe, string vreq);
    int new_app;
    chk("R2", u_o, exp_u);
    chk(vreq, v_o, exp_v);
    chk("R8", u_n_o, ~exp_u);
    chk("R8", v_n_o, ~exp_v);
    if (v_o === last_v) run_len++;
    else begin
      if (seen_edge) begin
        checks++;
        if (run_len < 2) begin
          errors++;
          $display("FAIL R5: actual run %0d expected >= 2 at %0t", run_len, $time);
        end
      end
      seen_edge = 1;
      run_len = 1;
      last_v = v_o;
    end
    pal_mode_i = pal;
    line_start_i = strobe;
    @(posedge clk);
    exp_u = (m_cnt < 2);
    exp_v = ((((m_cnt + 3) % 4) < 2) ? 1'b1 : 1'b0) ^ m_app[0];
    new_app = (m_cnt == 2) ? m_flag : m_app;
    m_flag = pal ? (m_flag ^ int'(strobe)) : 0;
    m_app = new_app;
    m_cnt = (m_cnt + 1) % 4;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", u_o, 1'b1);
    chk("R1", u_n_o, 1'b0);
    chk("R1", v_o, 1'b0);
    chk("R1", v_n_o, 1'b1);
    rst_ni = 1'b1;

    // NTSC: strobes must be ignored
    for (int i = 0; i < 40; i++) cyc(1'b0, (i % 7) == 3, "R3");

    // PAL: strobe swept over every counter phase, several lines each
    for (int p = 0; p < 4; p++) begin
      for (int line = 0; line < 6; line++) begin
        bit sent = 0;
        for (int i = 0; i < 13; i++) begin
          bit s = (i >= 4) && (m_cnt == p) && !sent;
          if (s) sent = 1;
          cyc(1'b1, s, (p == 2) ? "R6" : "R4");
        end
      end
    end

    // back-to-back strobes cancel
    for (int i = 0; i < 4; i++) cyc(1'b1, i < 2, "R4");
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, "R4");

    // force flag to 1 and let it apply, then leave PAL
    if (m_flag == 0) cyc(1'b1, 1'b1, "R4");
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, "R4");
    checks++;
    if (m_app != 1) begin
      errors++;
      $display("FAIL R7: actual applied %0d expected 1 before exit", m_app);
    end
    for (int i = 0; i < 24; i++) cyc(1'b0, (i % 5) == 1, "R7");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule